// File: doc/BRIEF.md
# Single-Byte SPI Master with Abort Recovery

This block is a serial peripheral interface master that exchanges one byte in both directions at once. A one-cycle start pulse, given while the block is idle, captures the byte to send and the two mode bits: clock polarity (CPOL) and clock phase (CPHA). The block then drives the serial clock, shifts the byte out on MOSI with the most significant bit first, and shifts MISO into a receive register. When the eighth bit has been captured, the received byte appears on a parallel output and stays there until another transfer completes. Busy marks the whole exchange.

The serial clock changes level once per system clock cycle, so one bit takes two cycles. A transfer takes one setup cycle and then sixteen half periods. A start pulse that arrives while the block is busy aborts the exchange. The sequencer moves into a dedicated abort state for one cycle, with the serial clock parked at its idle level and MOSI low. It then returns to idle by itself, and the last good receive byte is kept.

The sequencer keeps a fixed three-bit state code: idle 0, setup 1, leading half 2, trailing half 3, abort 6. Unused codes fall back to idle.

Top module: `spi_byte_master`

## Requirements
- R1: A start pulse seen while idle captures `tx_byte`, `mode_cpol` and `mode_cpha`, and `busy` is high in the next cycle. Changes to those three inputs after that edge have no effect on the running transfer.
- R2: The serial clock rests at the captured CPOL level, which is 0 after reset. During a transfer it holds the idle level for the setup cycle and then changes level on every cycle for 16 cycles, the first change going away from the idle level.
- R3: With CPHA=0, MOSI carries bit 7 from the cycle after the start edge and moves to the next lower bit on each return of the serial clock to idle. MISO is captured at the end of each cycle in which the serial clock is at its active level.
- R4: With CPHA=1, MOSI is low during the setup cycle and takes the next bit, starting with bit 7, each time the serial clock leaves its idle level. MISO is captured at the end of each cycle in which the serial clock is back at its idle level.
- R5: Received bits are assembled MSB first. `rx_byte` is loaded on the edge that captures the eighth bit, and it holds its value at all other times.
- R6: `busy` is high for exactly 17 cycles per completed transfer. It then drops with MOSI low, and a new transfer may start in the very next cycle.
- R7: A start pulse while busy sends the sequencer to the abort state (code 6) on that edge, with no capture on that edge. The abort state lasts one cycle, with `busy` high, MOSI low and the serial clock at its idle level. It is followed by idle with `busy` low, and `rx_byte` keeps its earlier value.
- R8: A start pulse seen while the sequencer is in the abort state is ignored: the sequencer still goes to idle and no transfer begins.
- R9: An active-low reset acts at once, with no clock edge needed. It forces idle, with `busy`, `sclk`, `mosi` and `rx_byte` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_byte | input | 8 | Byte to send, captured at start |
| mode_cpol | input | 1 | Clock polarity, captured at start |
| mode_cpha | input | 1 | Clock phase, captured at start |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | High while a transfer or abort is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| rx_byte | output | 8 | Last fully received byte |

## Verification
The bench's slave drives the correct MISO bit only during the capture window of the active phase and drives its inverse at other times. A design that captures on the wrong half period therefore assembles a complemented byte. A start pulse is aimed at the exact edge that would capture the eighth bit with CPHA=0. A design that lets that capture through alters `rx_byte` during the abort. A second start pulse is held through the abort cycle: a design that honours it raises `busy` again instead of resting idle. The mode and data inputs are changed in the middle of a transfer, and a design that fails to hold its captured copies shows wrong MOSI or serial clock levels on the very next cycle.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_LEAD   = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_ERROR  = 3'd6
  } spi_state_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  typedef struct packed {
    logic launch;      // idle -> setup
    logic lead;        // entering leading half period
    logic trail;       // leading -> trailing half period
    logic sample_exit; // leaving trailing half, not aborting
    logic abort;       // entering error state
    logic finish;      // trailing half of last bit -> idle
    logic last;        // current bit is the final one
  } spi_evt_t;

endpackage

// File: rtl/spi_byte_fsm.sv
module spi_byte_fsm
  import spi_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  spi_mode_t        mode_in,
  output spi_state_e       state_q,
  output spi_mode_t        mode_q,
  output spi_evt_t         evt,
  output logic             busy_q
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W - 1);

  spi_state_e       state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             mode_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   state_d = start ? ST_SETUP : ST_IDLE;
      ST_SETUP:  state_d = start ? ST_ERROR : ST_LEAD;
      ST_LEAD:   state_d = start ? ST_ERROR : ST_SAMPLE;
      ST_SAMPLE: begin
        if (start)              state_d = ST_ERROR;
        else if (cnt_q == '0)   state_d = ST_IDLE;
        else                    state_d = ST_LEAD;
      end
      ST_ERROR:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // event strobes for the datapath blocks
  always_comb begin
    evt.launch      = (state_q == ST_IDLE)   && (state_d == ST_SETUP);
    evt.lead        = (state_d == ST_LEAD);
    evt.trail       = (state_q == ST_LEAD)   && (state_d == ST_SAMPLE);
    evt.sample_exit = (state_q == ST_SAMPLE) && (state_d != ST_ERROR);
    evt.abort       = (state_d == ST_ERROR);
    evt.finish      = (state_q == ST_SAMPLE) && (state_d == ST_IDLE);
    evt.last        = (cnt_q == '0);
  end

  // bit counter next value
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (evt.launch) begin
      cnt_d  = CNT_TOP;
      cnt_en = 1'b1;
    end else if ((state_q == ST_SAMPLE) && (state_d == ST_LEAD)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  assign mode_en = evt.launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_in;
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_byte_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  spi_evt_t evt,
  input  logic     cpol_in,
  input  logic     cpol_q,
  output logic     sclk_q
);

  logic sclk_d;

  // active level only while in a leading half period
  always_comb begin
    if (evt.launch)      sclk_d = cpol_in;
    else if (evt.lead)   sclk_d = ~cpol_q;
    else                 sclk_d = cpol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_evt_t          evt,
  input  logic [DATA_W-1:0] tx_in,
  input  logic              cpha_in,
  input  logic              cpha_q,
  output logic              mosi_q
);

  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] shift_d;
  logic              mosi_d;
  logic              shift_en;
  logic              advance;

  // choose the edge on which the next bit is presented
  assign advance = cpha_q ? evt.lead : (evt.trail && !evt.last);

  always_comb begin
    shift_d  = shift_q;
    mosi_d   = mosi_q;
    shift_en = 1'b0;
    if (evt.launch) begin
      shift_en = 1'b1;
      if (cpha_in) begin
        shift_d = tx_in;
        mosi_d  = 1'b0;
      end else begin
        shift_d = tx_in << 1;
        mosi_d  = tx_in[DATA_W-1];
      end
    end else if (evt.abort || evt.finish) begin
      mosi_d = 1'b0;
    end else if (advance) begin
      shift_en = 1'b1;
      shift_d  = shift_q << 1;
      mosi_d   = shift_q[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mosi_q <= 1'b0;
    else        mosi_q <= mosi_d;
  end

endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture
  import spi_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_evt_t          evt,
  input  logic              cpha_q,
  input  logic              miso,
  output logic [DATA_W-1:0] rx_q
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_d;
  logic              capture;
  logic              load;

  // CPHA=0 captures leaving the leading half, CPHA=1 leaving the trailing half
  assign capture = cpha_q ? evt.sample_exit : evt.trail;
  assign load    = capture && evt.last;
  assign acc_d   = {acc_q[DATA_W-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (capture) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_q <= '0;
    else if (load) rx_q <= acc_d;
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              mode_cpol,
  input  logic              mode_cpha,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  spi_state_e state_q;
  spi_mode_t  mode_in;
  spi_mode_t  mode_q;
  spi_evt_t   evt;

  assign mode_in.cpol = mode_cpol;
  assign mode_in.cpha = mode_cpha;

  spi_byte_fsm #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode_in (mode_in),
    .state_q (state_q),
    .mode_q  (mode_q),
    .evt     (evt),
    .busy_q  (busy)
  );

  spi_sclk_gen u_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .cpol_in (mode_cpol),
    .cpol_q  (mode_q.cpol),
    .sclk_q  (sclk)
  );

  spi_tx_shift #(
    .DATA_W (DATA_W)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .tx_in   (tx_byte),
    .cpha_in (mode_cpha),
    .cpha_q  (mode_q.cpha),
    .mosi_q  (mosi)
  );

  spi_rx_capture #(
    .DATA_W (DATA_W)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .cpha_q (mode_q.cpha),
    .miso   (miso),
    .rx_q   (rx_byte)
  );

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              sclk,
  input logic              mosi,
  input logic [DATA_W-1:0] rx_byte,
  input logic [2:0]        state_q
);

  p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_sclk_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'd2) |-> (sclk != $past(sclk)));

  p_sclk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == 3'd0) && ($past(state_q) == 3'd0)) |-> $stable(sclk));

  p_rx_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'd6) |-> $stable(rx_byte));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'd0) |-> (!busy && !mosi));

  p_abort_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q != 3'd0) && (state_q != 3'd6)) |=> (state_q == 3'd6));

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'd0) || (state_q == 3'd1) || (state_q == 3'd2) ||
    (state_q == 3'd3) || (state_q == 3'd6));

  p_abort_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'd6) |=> ((state_q == 3'd0) && !busy));

endmodule

bind spi_byte_master spi_byte_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .sclk    (sclk),
  .mosi    (mosi),
  .rx_byte (rx_byte),
  .state_q (state_q)
);

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       mode_cpol = 1'b0;
  logic       mode_cpha = 1'b0;
  logic       miso = 1'b1;
  logic       busy;
  logic       sclk;
  logic       mosi;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  logic [7:0] slave_byte = 8'h00;
  bit         m_act = 0;
  bit         m_err = 0;
  int         m_t = 0;
  int         m_ncap = 0;
  int         k = 0;
  logic [7:0] m_tx = 8'h00;
  logic [7:0] m_pat = 8'h00;
  logic [7:0] m_acc = 8'h00;
  logic       m_cpol = 1'b0;
  logic       m_cpha = 1'b0;
  logic       e_busy = 1'b0;
  logic       e_sclk = 1'b0;
  logic       e_mosi = 1'b0;
  logic [7:0] e_rx = 8'h00;

  spi_byte_master #(.DATA_W(8)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_byte   (tx_byte),
    .mode_cpol (mode_cpol),
    .mode_cpha (mode_cpha),
    .miso      (miso),
    .busy      (busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .rx_byte   (rx_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // behavioural model, one step per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_err = 0; m_t = 0; m_ncap = 0; m_cpol = 1'b0; m_cpha = 1'b0;
      e_busy = 1'b0; e_sclk = 1'b0; e_mosi = 1'b0; e_rx = 8'h00;
    end else if (m_err) begin
      m_err = 0;
      e_busy = 1'b0; e_sclk = m_cpol; e_mosi = 1'b0;
    end else if (!m_act) begin
      if (start) begin
        m_act = 1; m_t = 0; m_ncap = 0;
        m_tx = tx_byte; m_cpol = mode_cpol; m_cpha = mode_cpha; m_pat = slave_byte;
        e_busy = 1'b1; e_sclk = mode_cpol;
        e_mosi = mode_cpha ? 1'b0 : tx_byte[7];
      end
    end else if (start) begin
      m_act = 0; m_err = 1;
      e_busy = 1'b1; e_sclk = m_cpol; e_mosi = 1'b0;
    end else begin
      if (((m_t % 2) == 1 && !m_cpha) || ((m_t % 2) == 0 && m_t >= 2 && m_cpha)) begin
        m_acc = {m_acc[6:0], miso};
        m_ncap++;
        if (m_ncap == 8) e_rx = m_acc;
      end
      m_t++;
      if (m_t == 17) begin
        m_act = 0;
        e_busy = 1'b0; e_sclk = m_cpol; e_mosi = 1'b0;
      end else begin
        k = 7 - (m_t - 1) / 2;
        if ((m_t % 2) == 1) begin
          e_sclk = ~m_cpol;
          if (m_cpha) e_mosi = m_tx[k];
        end else begin
          e_sclk = m_cpol;
          if (!m_cpha && k > 0) e_mosi = m_tx[k-1];
        end
      end
    end
  end

  // per-cycle comparison and slave drive, away from the active edge
  always @(negedge clk) begin
    check(busy === e_busy, m_err ? "R7" : "R6", "busy", 32'(busy), 32'(e_busy));
    check(sclk === e_sclk, "R2", "sclk", 32'(sclk), 32'(e_sclk));
    check(mosi === e_mosi, m_cpha ? "R4" : "R3", "mosi", 32'(mosi), 32'(e_mosi));
    check(rx_byte === e_rx, "R5", "rx_byte", 32'(rx_byte), 32'(e_rx));
    if (m_act && m_t >= 1 && m_t <= 16) begin
      if (m_cpha ? ((m_t % 2) == 0) : ((m_t % 2) == 1))
        miso <= m_pat[7 - (m_t - 1) / 2];
      else
        miso <= ~m_pat[7 - (m_t - 1) / 2];
    end else begin
      miso <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG_LIMIT);
      finish_run();
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] rx,
                          input logic cp, input logic ch, input string tag);
    int n;
    tx_byte = tx; mode_cpol = cp; mode_cpha = ch; slave_byte = rx;
    pulse_start();
    n = 0;
    while (busy && n < 40) begin
      n++;
      @(negedge clk);
    end
    check(n == 17, "R6", "busy cycles", 32'(n), 32'd17);
    check(rx_byte == rx, tag, "received byte", 32'(rx_byte), 32'(rx));
    check(sclk == cp, "R2", "idle sclk level", 32'(sclk), 32'(cp));
  endtask

  initial begin
    logic [7:0] held;
    // R9: reset acts without a clock edge
    #1;
    check(busy == 1'b0 && sclk == 1'b0 && mosi == 1'b0 && rx_byte == 8'h00,
          "R9", "outputs in reset", {busy, sclk, mosi, rx_byte}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && sclk == 1'b0, "R9", "after release", {busy, sclk}, 32'd0);

    run_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, "R3");
    run_xfer(8'h5A, 8'hC3, 1'b0, 1'b1, "R4");
    run_xfer(8'h81, 8'h7E, 1'b1, 1'b0, "R3");

    // R1: inputs changed mid-transfer are ignored
    tx_byte = 8'h96; mode_cpol = 1'b1; mode_cpha = 1'b1; slave_byte = 8'hF0;
    pulse_start();
    check(busy == 1'b1, "R1", "busy after start", 32'(busy), 32'd1);
    repeat (3) @(negedge clk);
    tx_byte = 8'h00; mode_cpol = 1'b0; mode_cpha = 1'b0;
    while (busy) @(negedge clk);
    check(rx_byte == 8'hF0, "R1", "byte with changed inputs", 32'(rx_byte), 32'hF0);
    check(sclk == 1'b1, "R1", "captured cpol kept", 32'(sclk), 32'd1);

    // R7 and R8: abort mid-transfer with start held through the abort cycle
    held = rx_byte;
    tx_byte = 8'h3C; mode_cpol = 1'b0; mode_cpha = 1'b1; slave_byte = 8'hA5;
    pulse_start();
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1 && mosi == 1'b0 && sclk == 1'b0, "R7", "abort cycle outputs",
          {busy, mosi, sclk}, 32'h4);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R8", "start in abort ignored", 32'(busy), 32'd0);
    check(rx_byte == held, "R7", "rx kept after abort", 32'(rx_byte), 32'(held));
    @(negedge clk);
    check(busy == 1'b0, "R8", "still idle", 32'(busy), 32'd0);

    // R7: abort on the edge that would capture the eighth bit (CPHA=0)
    tx_byte = 8'hC6; mode_cpol = 1'b1; mode_cpha = 1'b0; slave_byte = 8'h0F;
    pulse_start();
    repeat (15) @(negedge clk);
    pulse_start();
    check(busy == 1'b1 && sclk == 1'b1, "R7", "abort at last capture", {busy, sclk}, 32'h3);
    @(negedge clk);
    check(rx_byte == held, "R7", "no capture on abort edge", 32'(rx_byte), 32'(held));

    // R6 and R5: back-to-back transfers
    run_xfer(8'h69, 8'h5B, 1'b1, 1'b1, "R5");
    run_xfer(8'hFF, 8'h00, 1'b0, 1'b0, "R5");
    repeat (3) @(negedge clk);
    check(rx_byte == 8'h00, "R5", "rx held while idle", 32'(rx_byte), 32'h00);

    finish_run();
  end

endmodule